// File: doc/BRIEF.md
# Asynchronous Serial Character Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a single line. A frame is a low start slot, the data bits with the least significant bit first, an optional parity slot, then one, one and a half or two high stop slots. The line rests high between frames. Timing comes from an oversampling tick supplied from outside. Each bit slot spans `OVS` tick pulses, so a half stop slot spans `OVS/2` pulses.

A producer offers a character with `valid_i` and the block takes it in the cycle `ready_o` is high. The data and all line-control inputs are captured at that moment. The next character can be taken in the cycle that holds the final tick of the current frame, so frames can run back to back with no idle gap. A break input pulls the line low at any time without disturbing the frame sequencing underneath. `empty_o` tells the system when the last stop slot has fully left the line.

Top module: `uart_char_tx`

## Requirements
- R1: After reset `txd_o` is 1, `empty_o` is 1 and `ready_o` is 1.
- R2: A frame begins with one low start slot, followed by the data bits with the least significant bit first.
- R3: `len_i` codes 00, 01, 10 and 11 send 5, 6, 7 and 8 data bits. Data bits above the selected length are not sent.
- R4: With `stop2_i` at 0 the frame ends in one high stop slot. With `stop2_i` at 1 and a length of 6, 7 or 8 bits it ends in two full high stop slots.
- R5: With `stop2_i` at 1 and a 5-bit length, the frame ends in one full stop slot followed by a high slot of `OVS/2` ticks.
- R6: With `par_en_i` at 1, one parity slot follows the last data bit. With `par_even_i` at 1 the ones in the sent data plus parity are even in number; with `par_even_i` at 0 they are odd. With `par_en_i` at 0 there is no parity slot.
- R7: With `par_en_i` and `par_stick_i` both at 1, the parity slot is the inverse of `par_even_i`, whatever the data. With `par_en_i` at 0, `par_stick_i` has no effect.
- R8: While `brk_i` is 1, `txd_o` is 0, both in idle and during a frame. A break neither starts a frame nor shifts the timing or the later bits of a frame in progress.
- R9: `empty_o` goes low in the cycle after a character is taken. It stays low through the last tick of the final stop slot, and it is high in the next cycle unless a new character was taken.
- R10: `ready_o` is high while idle. During a frame it is high only in the cycle that holds the final tick of the last stop slot. A character taken in that cycle drives its start slot in the very next cycle.
- R11: Data and line-control inputs are sampled only when a character is taken. Later changes do not affect the frame in progress.
- R12: Each full slot lasts exactly `OVS` cycles in which `tick_i` is high, and the line holds its value across cycles without a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling tick; `OVS` pulses make one bit slot |
| data_i | input | 8 | Character to send |
| len_i | input | 2 | Data length code (5 + code bits) |
| stop2_i | input | 1 | Extended stop: 1.5 slots for 5-bit, 2 slots otherwise |
| par_en_i | input | 1 | Parity slot enable |
| par_even_i | input | 1 | Even parity select |
| par_stick_i | input | 1 | Stick parity select |
| brk_i | input | 1 | Forces the line low while high |
| valid_i | input | 1 | Character offered |
| ready_o | output | 1 | Character taken this cycle when `valid_i` is high |
| txd_o | output | 1 | Serial line, idle high |
| empty_o | output | 1 | No frame in progress |

## Verification
The bench builds the block with `OVS` set to 4, so the half stop slot is two ticks and an 8-bit frame with parity and two stops takes only 48 ticks. This keeps the cycle-exact checks of `ready_o` and `empty_o` short. It also leaves room to replay frames under a steady tick, a tick every third cycle and a pseudo-random tick. With a small `OVS`, the one-and-a-half stop case differs from two stops by an amount a tick-by-tick line comparison catches at once. Back-to-back handoff, a break mid-frame and changes to the inputs after capture are all checked against the same per-tick expected line.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int MAX_DATA = 8;
  localparam int MIN_DATA = 5;
  // start + data + parity + two stops
  localparam int FRAME_W  = 1 + MAX_DATA + 1 + 2;
  localparam int SLOT_W   = $clog2(FRAME_W + 1);
endpackage

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
(
  input  logic [MAX_DATA-1:0] data_i,
  input  logic [1:0]          len_i,
  input  logic                stop2_i,
  input  logic                par_en_i,
  input  logic                par_even_i,
  input  logic                par_stick_i,
  output logic [FRAME_W-1:0]  frame_o,
  output logic [SLOT_W-1:0]   nslots_o,
  output logic                last_half_o
);
  int unsigned         nb;
  int unsigned         ns;
  logic [MAX_DATA-1:0] mask;
  logic                xr;
  logic                pbit;

  always_comb begin
    nb = MIN_DATA + int'(len_i);
    for (int i = 0; i < MAX_DATA; i++) mask[i] = (i < int'(nb));
    xr = ^(data_i & mask);
    if (par_stick_i) pbit = ~par_even_i;
    else             pbit = par_even_i ? xr : ~xr;
    frame_o    = '1;
    frame_o[0] = 1'b0;
    for (int i = 0; i < MAX_DATA; i++)
      if (mask[i]) frame_o[1+i] = data_i[i];
    if (par_en_i) frame_o[1+nb] = pbit;
    ns = 1 + nb + (par_en_i ? 1 : 0) + (stop2_i ? 2 : 1);
    nslots_o    = SLOT_W'(ns);
    last_half_o = stop2_i && (len_i == 2'b00);
  end
endmodule

// File: rtl/uart_tx_pacer.sv
module uart_tx_pacer #(
  parameter int OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic load_i,
  input  logic half_i,
  output logic slot_end_o
);
  localparam int SUB_W = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [SUB_W-1:0] FULL_LIM = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] HALF_LIM = SUB_W'(OVS / 2 - 1);

  logic [SUB_W-1:0] sub_q;
  logic [SUB_W-1:0] lim;

  assign lim        = half_i ? HALF_LIM : FULL_LIM;
  assign slot_end_o = run_i && tick_i && (sub_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  sub_q <= '0;
    else if (load_i)              sub_q <= '0;
    else if (slot_end_o)          sub_q <= '0;
    else if (run_i && tick_i)     sub_q <= sub_q + SUB_W'(1);
  end

  // R12: no progress without a tick
  a_r12_sub_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(sub_q));
endmodule

// File: rtl/uart_char_tx.sv
module uart_char_tx
  import uart_tx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [7:0] data_i,
  input  logic [1:0] len_i,
  input  logic       stop2_i,
  input  logic       par_en_i,
  input  logic       par_even_i,
  input  logic       par_stick_i,
  input  logic       brk_i,
  input  logic       valid_i,
  output logic       ready_o,
  output logic       txd_o,
  output logic       empty_o
);
  logic [FRAME_W-1:0] frm_d, frm_q;
  logic [SLOT_W-1:0]  nslots_d, slots_q;
  logic               half_d, half_q;
  logic               busy_q;
  logic               last_q;
  logic               slot_end;
  logic               accept;

  uart_tx_framer u_framer (
    .data_i      (data_i),
    .len_i       (len_i),
    .stop2_i     (stop2_i),
    .par_en_i    (par_en_i),
    .par_even_i  (par_even_i),
    .par_stick_i (par_stick_i),
    .frame_o     (frm_d),
    .nslots_o    (nslots_d),
    .last_half_o (half_d)
  );

  assign last_q = (slots_q == SLOT_W'(1));

  uart_tx_pacer #(.OVS(OVS)) u_pacer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .run_i      (busy_q),
    .load_i     (accept),
    .half_i     (half_q && last_q),
    .slot_end_o (slot_end)
  );

  assign ready_o = !busy_q || (slot_end && last_q);
  assign accept  = valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      frm_q   <= '1;
      slots_q <= '0;
      half_q  <= 1'b0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      frm_q   <= frm_d;
      slots_q <= nslots_d;
      half_q  <= half_d;
    end else if (slot_end) begin
      if (last_q) begin
        busy_q <= 1'b0;
        frm_q  <= '1;
      end else begin
        frm_q <= {1'b1, frm_q[FRAME_W-1:1]};
      end
      slots_q <= slots_q - SLOT_W'(1);
    end
  end

  // break overrides the line only; sequencing runs on
  assign txd_o   = brk_i ? 1'b0 : (busy_q ? frm_q[0] : 1'b1);
  assign empty_o = !busy_q;

  a_r2_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (brk_i || !txd_o));
  a_r9_idle_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (txd_o || brk_i));
  a_r9_done_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_end && last_q && !accept) |=> empty_o);
  a_r10_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && busy_q) |=> !empty_o);
  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !accept) |=> ($stable(frm_q) && $stable(slots_q)));
endmodule

// File: tb/uart_char_tx_bench.sv
module uart_char_tx_bench;
  localparam int OVS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] data_i = '0;
  logic [1:0] len_i = '0;
  logic       stop2_i = 1'b0, par_en_i = 1'b0, par_even_i = 1'b0, par_stick_i = 1'b0;
  logic       brk = 1'b0;
  logic       valid = 1'b0;
  logic       ready_o, txd, empty_o;

  int total = 0;
  int bad = 0;

  uart_char_tx #(.OVS(OVS)) u_uart_char_tx (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tick_i      (tick),
    .data_i      (data_i),
    .len_i       (len_i),
    .stop2_i     (stop2_i),
    .par_en_i    (par_en_i),
    .par_even_i  (par_even_i),
    .par_stick_i (par_stick_i),
    .brk_i       (brk),
    .valid_i     (valid),
    .ready_o     (ready_o),
    .txd_o       (txd),
    .empty_o     (empty_o)
  );

  always #4 clk = ~clk;

  int         tick_mode = 0;
  int         tcnt = 0;
  logic [7:0] lfsr = 8'h5a;
  always @(posedge clk) begin
    #2;
    tcnt++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (tick_mode)
      0:       tick = 1'b1;
      1:       tick = (tcnt % 3 == 0);
      default: tick = lfsr[0];
    endcase
  end

  logic [191:0] q_lv[$];
  int           q_n[$];
  string        q_tag[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic add_slot(inout logic [191:0] lv, inout int n, input logic b, input int d);
    for (int k = 0; k < d; k++) begin
      lv[n] = b;
      n++;
    end
  endtask

  task automatic send(input logic [7:0] d, input logic [1:0] l, input logic s2,
                      input logic pe, input logic ev, input logic st, input string tag);
    logic [191:0] lv;
    int           n;
    int           nb;
    int           ones;
    logic         p;
    @(negedge clk);
    data_i = d; len_i = l; stop2_i = s2; par_en_i = pe; par_even_i = ev; par_stick_i = st;
    valid = 1'b1;
    while (!ready_o) @(negedge clk);
    lv = '0; n = 0; ones = 0;
    nb = 5 + int'(l);
    add_slot(lv, n, 1'b0, OVS);
    for (int i = 0; i < nb; i++) begin
      add_slot(lv, n, d[i], OVS);
      ones += int'(d[i]);
    end
    if (st) p = ~ev;
    else    p = ev ? ones[0] : ~ones[0];
    if (pe) add_slot(lv, n, p, OVS);
    add_slot(lv, n, 1'b1, OVS);
    if (s2) add_slot(lv, n, 1'b1, (nb == 5) ? OVS / 2 : OVS);
    q_lv.push_back(lv); q_n.push_back(n); q_tag.push_back(tag);
    @(posedge clk);
    #1;
    // R11: disturb every captured input after acceptance
    data_i = ~d; len_i = ~l; stop2_i = ~s2; par_en_i = ~pe; par_even_i = ~ev; par_stick_i = ~st;
    valid = 1'b0;
  endtask

  // scoreboard monitor: one line sample per tick
  bit           in_fr = 0;
  int           idx = 0;
  logic [191:0] cur_lv;
  int           cur_n = 0;
  string        cur_tag;
  bit           cur_err = 0;
  int           e_idx = 0;
  logic         e_got, e_exp;
  always @(negedge clk) begin
    if (rst_n && tick) begin
      if (!in_fr && !txd && !brk) begin
        if (q_n.size() == 0) begin
          check(1'b0, "R2", "unexpected start", 0, 1);
        end else begin
          cur_lv = q_lv.pop_front(); cur_n = q_n.pop_front(); cur_tag = q_tag.pop_front();
          in_fr = 1; idx = 0; cur_err = 0;
        end
      end
      if (in_fr) begin
        e_exp = brk ? 1'b0 : cur_lv[idx];
        if (txd !== e_exp && !cur_err) begin
          cur_err = 1; e_idx = idx; e_got = txd;
        end
        idx++;
        if (idx == cur_n) begin
          in_fr = 0;
          total++;
          if (cur_err) begin
            bad++;
            $display("FAIL %s frame tick %0d: got %0d expected %0d",
                     cur_tag, e_idx, e_got, cur_lv[e_idx]);
          end
        end
      end
    end
  end

  task automatic wait_done();
    while (q_n.size() != 0 || in_fr) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R10 watchdog expired: got 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(txd == 1'b1,     "R1", "txd after reset",   int'(txd), 1);
    check(empty_o == 1'b1, "R1", "empty after reset", int'(empty_o), 1);
    check(ready_o == 1'b1, "R1", "ready after reset", int'(ready_o), 1);

    // data lengths, LSB first
    send(8'hA5, 2'b11, 0, 0, 0, 0, "R2 8-bit");
    send(8'hF3, 2'b00, 0, 0, 0, 0, "R3 5-bit upper ignored");
    send(8'h2D, 2'b01, 0, 0, 0, 0, "R3 6-bit");
    send(8'hD5, 2'b10, 0, 0, 0, 0, "R3 7-bit");
    wait_done();

    // stop bits
    send(8'h3C, 2'b10, 1, 0, 0, 0, "R4 two stops");
    send(8'h11, 2'b11, 1, 1, 1, 0, "R4 two stops parity");
    send(8'h16, 2'b00, 1, 0, 0, 0, "R5 half stop");
    send(8'h0B, 2'b00, 1, 1, 0, 0, "R5 half stop parity");
    wait_done();

    // parity
    send(8'hA5, 2'b11, 0, 1, 1, 0, "R6 even");
    send(8'hA5, 2'b11, 0, 1, 0, 0, "R6 odd");
    send(8'h07, 2'b11, 0, 1, 1, 0, "R6 even odd-count");
    send(8'hFF, 2'b00, 0, 1, 0, 0, "R6 odd 5-bit");
    send(8'hFF, 2'b11, 0, 1, 1, 1, "R7 stick zero");
    send(8'h00, 2'b11, 0, 1, 0, 1, "R7 stick one");
    send(8'h5A, 2'b11, 0, 0, 1, 1, "R7 stick without parity");
    wait_done();

    // empty/ready timing: 5N1 = 7 slots = 28 ticks
    send(8'h00, 2'b00, 0, 0, 0, 0, "R9 timed frame");
    @(negedge clk);
    check(empty_o == 1'b0, "R9",  "empty after accept", int'(empty_o), 0);
    check(ready_o == 1'b0, "R10", "ready while busy",   int'(ready_o), 0);
    repeat (27) @(negedge clk);
    check(ready_o == 1'b1, "R10", "ready at final tick", int'(ready_o), 1);
    check(empty_o == 1'b0, "R9",  "empty at final tick", int'(empty_o), 0);
    @(negedge clk);
    check(empty_o == 1'b1, "R9", "empty after stop", int'(empty_o), 1);
    check(txd == 1'b1,     "R9", "idle line",        int'(txd), 1);
    wait_done();

    // back to back
    send(8'h81, 2'b11, 0, 0, 0, 0, "R10 first");
    send(8'h7E, 2'b11, 0, 1, 1, 0, "R10 second");
    @(negedge clk);
    check(empty_o == 1'b0, "R10", "empty on handoff", int'(empty_o), 0);
    check(txd == 1'b0,     "R10", "start on handoff", int'(txd), 0);
    wait_done();

    // break in idle
    @(posedge clk); #3 brk = 1'b1;
    @(negedge clk);
    check(txd == 1'b0, "R8", "break idle line", int'(txd), 0);
    repeat (5) @(negedge clk);
    check(empty_o == 1'b1, "R8", "break starts no frame", int'(empty_o), 1);
    @(posedge clk); #3 brk = 1'b0;
    @(negedge clk);
    check(txd == 1'b1, "R8", "line after break", int'(txd), 1);

    // break mid-frame
    send(8'h96, 2'b11, 1, 1, 1, 0, "R8 mid-frame");
    repeat (6) @(negedge clk);
    @(posedge clk); #3 brk = 1'b1;
    @(negedge clk);
    check(txd == 1'b0, "R8", "break mid-frame", int'(txd), 0);
    repeat (7) @(posedge clk);
    #3 brk = 1'b0;
    wait_done();

    // irregular ticks
    for (int m = 1; m <= 2; m++) begin
      tick_mode = m;
      for (int i = 0; i < 4; i++) begin
        send(8'(37 * i + 11 * m), 2'(i), i[0], (i > 1), i[1], (m == 2 && i == 3),
             "R11/R12 irregular tick");
      end
      wait_done();
    end
    tick_mode = 0;

    check(q_n.size() == 0 && !in_fr, "R10", "all frames delivered", q_n.size(), 0);
    summary();
    $finish;
  end
endmodule